// File: doc/BRIEF.md
# NAND Flash Command Interface Decoder

This block is the device-side command and state logic of an 8-bit multiplexed NAND flash interface. The host drives strobes and an 8-bit bus. Each rising write-strobe edge seen while chip-enable is low is classified as one of three kinds: a command (command-latch high), an address (address-latch high) or a data byte (neither high). The block keeps a column pointer into a 528-byte page register. That register is 512 main bytes followed by 16 spare bytes, and the pointer can be aimed at the lower half, the upper half or the spare bytes. The block runs the page read, page load and program, block erase, status, identification and reset sequences, and reports progress through a ready output and a status byte.

No cell array is modelled. The page register is a small synthesizable buffer. A programmable countdown timer stands in for the array latency of read, program, erase and reset. Every strobe is sampled on the system clock, and strobe edges are found by comparing each sample with the one before it.

Top module: `nand_cmd_if`

## Requirements
- R1: A bus cycle is taken only on a rising edge of `we_n` while `ce_n` is low. With `cle` high and `ale` low it is a command, with `ale` high and `cle` low it is an address, and with both low it is data. Any cycle with `ce_n` high has no effect.
- R2: Opcode 00h aims the pointer at the lower half. The first address byte sets column = byte value. Three address cycles (column, row low, row high) start a read, which holds `rdy` low for READ_CYC clocks. Afterwards the reads return the page register from that column on. In read mode, address cycles without a new command start another read.
- R3: Opcode 01h aims the pointer at the upper half, so column = 256 + first address byte. After the third address cycle of that operation, the area falls back to the lower half by itself.
- R4: Opcode 50h aims the pointer at the spare bytes, so column = 512 + address bits [3:0]; bits [7:4] are ignored. The spare selection stays in force until 00h or 01h is written.
- R5: Each falling edge of `re_n` with `ce_n` low, while ready, puts the byte at the pointer on `io_out` and then advances the pointer. The pointer stops at column 527.
- R6: The sequence 80h, three address cycles, data bytes, 10h does two things. The data bytes are written into the page register at consecutive columns, and the 10h holds `rdy` low for PROG_CYC clocks. A 10h that no data byte has preceded is ignored.
- R7: The sequence 60h, two address cycles, D0h holds `rdy` low for ERASE_CYC clocks and sets every page-register byte to FFh. A D0h that arrives before both address cycles is ignored.
- R8: While `rdy` is low, the only commands accepted are 70h and FFh. Any other opcode leaves the mode unchanged.
- R9: The status byte is bit 7 = `wp_n`, bit 6 = ready, bit 0 = fail, with all other bits 0. After 70h, and after a program or erase confirm, every read returns the live status byte. This lasts until another command is written, so a read opcode is needed before page data can be read again.
- R10: A program or erase that is confirmed while `wp_n` is low sets fail (bit 0 = 1), and such an erase leaves the page register unchanged. A confirm with `wp_n` high clears fail.
- R11: Opcode 90h followed by one address cycle of 00h makes the next reads return ECh, then 73h, then 00h.
- R12: Opcode FFh aborts any busy operation and holds `rdy` low for RST_CYC clocks. It also clears the column to 0, sets the page register to all FFh, clears fail and returns to lower-half read mode, so status reads C0h with `wp_n` high. A second FFh with no other command in between is ignored.
- R13: After `rst_n`, the block is in lower-half read mode at column 0, with `rdy` high and every page byte FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low, taken on its rising edge |
| re_n | input | 1 | Read strobe, active low, taken on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Command, address and data bus from the host |
| io_out | output | 8 | Read data, status or identification byte |
| io_oe | output | 1 | High while the block drives the bus |
| rdy | output | 1 | High when no operation is in progress |

## Verification
A reset command can arrive in the same clock cycle in which the busy timer of a running program expires. In that cycle, aborting the operation and completing it compete for the timer and for the mode. The bench repeats a one-byte program and writes FFh at every clock offset from the confirm to just past the end of the program time, so one offset lands exactly on the expiry cycle. At every offset it requires that `rdy` stays low for exactly the reset time, that status then reads C0h, and that the page register afterwards reads all FFh.

// File: rtl/nci_pkg.sv
// Shared types and opcodes for the NAND command interface decoder.
// Assumes an 8-bit command bus; opcode values are fixed by the host protocol.
package nci_pkg;
    typedef enum logic [2:0] {
        M_READ, M_PROG, M_ERASE, M_STATUS, M_ID_ADDR, M_ID
    } mode_t;

    typedef enum logic [1:0] {
        A_LOWER, A_UPPER, A_SPARE
    } area_t;

    localparam logic [7:0] OP_RD_LO   = 8'h00;
    localparam logic [7:0] OP_RD_HI   = 8'h01;
    localparam logic [7:0] OP_RD_SP   = 8'h50;
    localparam logic [7:0] OP_LOAD    = 8'h80;
    localparam logic [7:0] OP_PCONF   = 8'h10;
    localparam logic [7:0] OP_ESETUP  = 8'h60;
    localparam logic [7:0] OP_ECONF   = 8'hD0;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] ID_MAKER   = 8'hEC;
    localparam logic [7:0] ID_DEVICE  = 8'h73;
endpackage

// File: rtl/nci_strobe.sv
// Strobe edge finder: turns sampled we_n/re_n levels into one-clock pulses.
// Assumes the strobes are already synchronous to clk and stay stable for
// at least one clock per level; pulses are gated by chip enable.
module nci_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic re_n,
    output logic we_rise,
    output logic re_fall
);
    logic we_q;
    logic re_q;

    // Hold the previous strobe levels (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    // Edge pulses, only while the device is selected.
    always_comb begin
        we_rise = ~ce_n & ~we_q & we_n;
        re_fall = ~ce_n & re_q & ~re_n;
    end
endmodule

// File: rtl/nci_busy_timer.sv
// Busy countdown: a load starts (or restarts) a countdown; busy while nonzero.
// Assumes load values are at least 1; a load wins over the running count.
module nci_busy_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          busy
);
    logic [TW-1:0] cnt;

    // Count down to zero; a new load overrides.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/nci_page_reg.sv
// Page register: one write port, one combinational read port, bulk fill to FFh.
// Assumes fill and write never need to coexist (fill wins).
module nci_page_reg #(
    parameter int DEPTH = 528,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    // Bulk fill on reset or request, otherwise single-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n || fill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nand_cmd_if.sv
// NAND command interface decoder (top). Sorts bus cycles into command,
// address and data; keeps the column pointer and area; sequences read,
// program, erase, status, ID and reset; drives rdy and the status byte.
// Assumes host strobes are synchronous to clk; array latency is modelled by
// the busy timer and the page register stands in for the cell array.
module nand_cmd_if
    import nci_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int READ_CYC    = 8,
    parameter int PROG_CYC    = 24,
    parameter int ERASE_CYC   = 40,
    parameter int RST_CYC     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rdy
);
    localparam int COLS  = MAIN_BYTES + SPARE_BYTES;
    localparam int HALF  = MAIN_BYTES / 2;
    localparam int CW    = $clog2(COLS);
    localparam int SW    = $clog2(SPARE_BYTES);
    localparam int MAXA  = (READ_CYC > PROG_CYC) ? READ_CYC : PROG_CYC;
    localparam int MAXB  = (ERASE_CYC > RST_CYC) ? ERASE_CYC : RST_CYC;
    localparam int TW    = $clog2(((MAXA > MAXB) ? MAXA : MAXB) + 1);

    mode_t         mode;
    area_t         area;
    logic [CW-1:0] col;
    logic [1:0]    addr_cnt;
    logic          data_seen;
    logic          fail;
    logic          in_rst;
    logic [1:0]    id_idx;
    logic [7:0]    dout_q;

    logic          we_rise, re_fall, busy;
    logic          cmd_stb, addr_stb, data_stb, accept;
    logic          go_read, go_prog, go_erase, go_reset;
    logic          tmr_load, pg_fill, pg_wr;
    logic [TW-1:0] tmr_val;
    logic [7:0]    pg_rd, status, id_byte;
    logic [CW-1:0] col_inc, col_start;

    nci_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
        .we_rise(we_rise), .re_fall(re_fall)
    );

    nci_busy_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .busy(busy)
    );

    nci_page_reg #(.DEPTH(COLS), .AW(CW)) u_page (
        .clk(clk), .rst_n(rst_n), .fill(pg_fill), .wr_en(pg_wr),
        .wr_addr(col), .wr_data(io_in), .rd_addr(col), .rd_data(pg_rd)
    );

    // Cycle classification and operation start decisions.
    always_comb begin
        cmd_stb  = we_rise & cle & ~ale;
        addr_stb = we_rise & ale & ~cle;
        data_stb = we_rise & ~cle & ~ale;
        accept   = cmd_stb & (~busy | io_in == OP_STATUS | io_in == OP_RESET)
                   & ~(io_in == OP_RESET & in_rst);
        go_reset = accept & (io_in == OP_RESET);
        go_prog  = accept & (io_in == OP_PCONF) & (mode == M_PROG) & data_seen;
        go_erase = accept & (io_in == OP_ECONF) & (mode == M_ERASE) & (addr_cnt == 2'd2);
        go_read  = addr_stb & ~busy & (mode == M_READ) & (addr_cnt == 2'd2);
        pg_wr    = data_stb & ~busy & (mode == M_PROG) & (addr_cnt == 2'd3);
        pg_fill  = go_reset | (go_erase & wp_n);
    end

    // Busy timer load selection; reset has priority.
    always_comb begin
        tmr_load = go_reset | go_prog | go_erase | go_read;
        if (go_reset)      tmr_val = TW'(RST_CYC);
        else if (go_prog)  tmr_val = TW'(PROG_CYC);
        else if (go_erase) tmr_val = TW'(ERASE_CYC);
        else               tmr_val = TW'(READ_CYC);
    end

    // Pointer arithmetic: saturating step and area-based start column.
    always_comb begin
        col_inc = (col == CW'(COLS - 1)) ? col : col + 1'b1;
        case (area)
            A_UPPER: col_start = CW'(HALF) + CW'(io_in);
            A_SPARE: col_start = CW'(MAIN_BYTES) + CW'(io_in[SW-1:0]);
            default: col_start = CW'(io_in);
        endcase
        status  = {wp_n, ~busy, 5'b0, fail};
        id_byte = (id_idx == 2'd0) ? ID_MAKER : (id_idx == 2'd1) ? ID_DEVICE : 8'h00;
    end

    // Command, address, data and read sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= M_READ;
            area      <= A_LOWER;
            col       <= '0;
            addr_cnt  <= '0;
            data_seen <= 1'b0;
            fail      <= 1'b0;
            in_rst    <= 1'b0;
            id_idx    <= '0;
            dout_q    <= '0;
        end else begin
            if (accept) begin
                in_rst <= (io_in == OP_RESET);
                case (io_in)
                    OP_RD_LO:   begin mode <= M_READ; area <= A_LOWER; addr_cnt <= '0; end
                    OP_RD_HI:   begin mode <= M_READ; area <= A_UPPER; addr_cnt <= '0; end
                    OP_RD_SP:   begin mode <= M_READ; area <= A_SPARE; addr_cnt <= '0; end
                    OP_LOAD:    begin mode <= M_PROG; addr_cnt <= '0; data_seen <= 1'b0; end
                    OP_ESETUP:  begin mode <= M_ERASE; addr_cnt <= '0; end
                    OP_STATUS:  mode <= M_STATUS;
                    OP_IDENT:   mode <= M_ID_ADDR;
                    OP_PCONF:   if (go_prog) begin
                                    mode <= M_STATUS; fail <= ~wp_n; data_seen <= 1'b0;
                                end
                    OP_ECONF:   if (go_erase) begin
                                    mode <= M_STATUS; fail <= ~wp_n;
                                end
                    OP_RESET:   begin
                                    mode <= M_READ; area <= A_LOWER; col <= '0;
                                    addr_cnt <= '0; fail <= 1'b0; data_seen <= 1'b0;
                                end
                    default:    ;
                endcase
            end else if (addr_stb && !busy) begin
                case (mode)
                    M_READ, M_PROG: if (addr_cnt != 2'd3) begin
                        if (addr_cnt == 2'd0) col <= col_start;
                        if (addr_cnt == 2'd2 && area == A_UPPER) area <= A_LOWER;
                        addr_cnt <= (mode == M_READ && addr_cnt == 2'd2) ? 2'd0
                                                                        : addr_cnt + 2'd1;
                    end
                    M_ERASE:   if (addr_cnt < 2'd2) addr_cnt <= addr_cnt + 2'd1;
                    M_ID_ADDR: if (io_in == 8'h00) begin mode <= M_ID; id_idx <= '0; end
                    default:   ;
                endcase
            end else if (pg_wr) begin
                col       <= col_inc;
                data_seen <= 1'b1;
            end
            if (re_fall && !busy) begin
                if (mode == M_READ) begin
                    dout_q <= pg_rd;
                    col    <= col_inc;
                end else if (mode == M_ID) begin
                    dout_q <= id_byte;
                    if (id_idx != 2'd2) id_idx <= id_idx + 2'd1;
                end
            end
        end
    end

    // Output mux: live status in status mode, otherwise the latched byte.
    assign io_out = (mode == M_STATUS) ? status : dout_q;
    assign io_oe  = ~ce_n & ~re_n;
    assign rdy    = ~busy;
endmodule

// File: rtl/nci_checker.sv
// Property checker for nand_cmd_if, attached by bind below.
// Assumes it sees the top's internal strobes and state read-only.
module nci_checker
    import nci_pkg::*;
#(
    parameter int COLS = 528,
    parameter int CW   = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rdy,
    input logic          wp_n,
    input logic [7:0]    io_in,
    input logic [7:0]    io_out,
    input logic          cmd_stb,
    input logic [CW-1:0] col,
    input mode_t         mode,
    input logic          data_seen,
    input logic          in_rst
);
    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        col <= CW'(COLS - 1)); // R5

    AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && cmd_stb && io_in == 8'h80) |=> (mode == $past(mode))); // R8

    AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STATUS) |-> (io_out[6] == rdy && io_out[7] == wp_n)); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && io_in == 8'hFF && !in_rst) |=> (col == '0 && !rdy)); // R12

    AST_BARE_CONFIRM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && cmd_stb && io_in == 8'h10 && !(mode == M_PROG && data_seen)) |=> rdy); // R6
endmodule

bind nand_cmd_if nci_checker #(.COLS(COLS), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .wp_n(wp_n), .io_in(io_in),
    .io_out(io_out), .cmd_stb(cmd_stb), .col(col), .mode(mode),
    .data_seen(data_seen), .in_rst(in_rst)
);

// File: tb/nand_cmd_if_tb.sv
module nand_cmd_if_tb;
    localparam int MAIN  = 512;
    localparam int HALF  = 256;
    localparam int COLS  = 528;
    localparam int T_RD  = 8;
    localparam int T_PG  = 24;
    localparam int T_ER  = 40;
    localparam int T_RS  = 5;

    logic clk = 0, rst_n = 0, ce_n = 0, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1;
    logic [7:0] io_in = 0;
    logic [7:0] io_out;
    logic io_oe, rdy;
    int total = 0, bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    nand_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rdy(rdy)
    );

    function automatic logic [7:0] pat(int c);
        return 8'((c * 37 + 11) & 255);
    endfunction

    task automatic chk(string rq, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic bus(logic c, logic a, logic [7:0] v);
        @(negedge clk);
        cle = c; ale = a; io_in = v; we_n = 0;
        repeat (2) @(negedge clk);
        we_n = 1;
        repeat (2) @(negedge clk);
        cle = 0; ale = 0;
    endtask

    task automatic cmd(logic [7:0] v);  bus(1, 0, v); endtask
    task automatic adr(logic [7:0] v);  bus(0, 1, v); endtask
    task automatic din(logic [7:0] v);  bus(0, 0, v); endtask
    task automatic adr3(logic [7:0] c); adr(c); adr(8'h00); adr(8'h00); endtask

    task automatic rd(output logic [7:0] v);
        re_n = 0;
        repeat (2) @(negedge clk);
        v = io_out;
        re_n = 1;
        @(negedge clk);
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!rdy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R13: power-up state
        chk("R13 rdy", rdy, 1);
        rd(v); chk("R13 page0 erased", v, 8'hFF);
        cmd(8'h70); rd(v); chk("R13 R9 status", v, 8'hC0);

        // R6: fill whole page register
        cmd(8'h80); adr3(8'h00);
        for (int c = 0; c < COLS; c++) din(pat(c));
        cmd(8'h10); chk("R6 busy", rdy, 0);
        wait_rdy(n); chk("R6 prog time", n, T_PG - 1);
        rd(v); chk("R9 status after prog", v, 8'hC0);
        cmd(8'h70); rd(v); chk("R9 sticky 1", v, 8'hC0); rd(v); chk("R9 sticky 2", v, 8'hC0);

        // R2 / R5: lower-half read
        cmd(8'h00); adr3(8'h10);
        chk("R2 busy", rdy, 0);
        wait_rdy(n); chk("R2 read time", n, T_RD - 1);
        for (int i = 0; i < 20; i++) begin rd(v); chk("R2 R5 seq", v, pat(16 + i)); end
        adr3(8'd250); wait_rdy(n);
        for (int i = 0; i < 10; i++) begin rd(v); chk("R2 cross half", v, pat(250 + i)); end

        // R3: upper half then automatic fallback
        cmd(8'h01); adr3(8'h05); wait_rdy(n);
        rd(v); chk("R3 upper", v, pat(HALF + 5));
        rd(v); chk("R3 upper next", v, pat(HALF + 6));
        adr3(8'h05); wait_rdy(n);
        rd(v); chk("R3 fallback", v, pat(5));

        // R4 / R5: spare area, saturation, stickiness
        cmd(8'h50); adr3(8'hA3); wait_rdy(n);
        for (int i = 0; i < 16; i++) begin
            rd(v);
            chk("R4 R5 spare sat", v, pat((MAIN + 3 + i > COLS - 1) ? COLS - 1 : MAIN + 3 + i));
        end
        adr3(8'h02); wait_rdy(n);
        rd(v); chk("R4 sticky", v, pat(MAIN + 2));

        // R1: CE high ignored, ALE cycle is address, plain data ignored in read
        ce_n = 1; cmd(8'h70); ce_n = 0;
        rd(v); chk("R1 ce high", v, pat(MAIN + 3));
        cmd(8'h00); adr3(8'h70); wait_rdy(n);
        rd(v); chk("R1 ale addr", v, pat(8'h70));
        din(8'h33);
        rd(v); chk("R1 data ignored", v, pat(8'h71));

        // R11: identification
        cmd(8'h90); adr(8'h00);
        rd(v); chk("R11 maker", v, 8'hEC);
        rd(v); chk("R11 device", v, 8'h73);
        rd(v); chk("R11 after", v, 8'h00);

        // R6: bare confirm ignored
        cmd(8'h80); adr3(8'h00); cmd(8'h10);
        chk("R6 bare confirm", rdy, 1);
        cmd(8'h00); cmd(8'h10);
        chk("R6 confirm in read", rdy, 1);

        // R8: commands during busy ignored
        cmd(8'h80); adr3(8'h00); din(8'h5A); cmd(8'h10);
        cmd(8'h90); cmd(8'h00);
        wait_rdy(n);
        rd(v); chk("R8 still status", v, 8'hC0);
        cmd(8'h00); adr3(8'h00); wait_rdy(n);
        rd(v); chk("R6 byte written", v, 8'h5A);
        rd(v); chk("R6 neighbour kept", v, pat(1));

        // R10: write protect
        wp_n = 0;
        cmd(8'h80); adr3(8'h00); din(8'h5A); cmd(8'h10); wait_rdy(n);
        rd(v); chk("R10 prog fail", v, 8'h41);
        cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'hD0); wait_rdy(n);
        rd(v); chk("R10 erase fail", v, 8'h41);
        cmd(8'h00); adr3(8'h00); wait_rdy(n);
        rd(v); chk("R10 erase blocked", v, 8'h5A);
        wp_n = 1;

        // R7: erase
        cmd(8'h60); adr(8'h00); cmd(8'hD0);
        chk("R7 early confirm", rdy, 1);
        adr(8'h00); cmd(8'hD0);
        wait_rdy(n); chk("R7 erase time", n, T_ER - 1);
        rd(v); chk("R10 pass clears", v, 8'hC0);
        cmd(8'h00); adr3(8'h00); wait_rdy(n);
        rd(v); chk("R7 erased 0", v, 8'hFF);
        adr3(8'd44); wait_rdy(n);
        rd(v); chk("R7 erased 44", v, 8'hFF);

        // R12: reset at every offset across a program's busy window
        for (int off = 0; off <= T_PG + 1; off++) begin
            cmd(8'h80); adr3(8'h00); din(8'(off)); cmd(8'h10);
            repeat (off) @(negedge clk);
            cmd(8'hFF);
            wait_rdy(n); chk("R12 reset time", n, T_RS - 1);
            cmd(8'h70); rd(v); chk("R12 status C0", v, 8'hC0);
            cmd(8'h00); adr3(8'h00); wait_rdy(n);
            rd(v); chk("R12 page filled", v, 8'hFF);
        end

        // R12: second reset ignored
        cmd(8'hFF); wait_rdy(n);
        cmd(8'hFF);
        chk("R12 repeat ignored", rdy, 1);
        rd(v); chk("R12 col cleared", v, 8'hFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule